// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Gated Status Flags

This block is the arithmetic and logic core of a small multi-cycle processor datapath. It takes two 8-bit operands and a 4-bit operation code and produces the result combinationally. The operations are add, subtract, bitwise AND, OR, XOR, NOT, a one-bit shift in either direction, and a pass-through of operand B. The pass-through serves register moves and immediate loads.

Alongside the result, a 4-bit status register holds Zero, Carry, Negative and Overflow. The register loads on a rising clock edge only when the flag-update enable is high and the operation code is a defined one. The controller raises the enable for ALU-class instructions and keeps it low for loads, stores and branches. A load placed between a compare and the branch that tests it therefore leaves the compare's flags in place.

Subtraction reuses the adder: operand B is inverted and the carry-in is forced to one. Arithmetic is two's complement. Carry reports the unsigned carry-out and Overflow reports signed overflow.

Top module: `alu_flags_unit`

## Requirements
- R1: Code 0 (ADD) gives res_o = (a_i + b_i) mod 256. The flag Carry is the unsigned carry-out. The flag Overflow is set when both operands have the same sign and the result has the opposite sign.
- R2: Code 1 (SUB) gives res_o = (a_i - b_i) mod 256. Carry is set exactly when a_i >= b_i as unsigned numbers, meaning no borrow. Overflow is set when the operands differ in sign and the result's sign differs from a_i.
- R3: Code 2 gives a_i AND b_i, code 3 gives a_i OR b_i, code 4 gives a_i XOR b_i, and code 5 gives NOT a_i. Each of these clears Carry and Overflow.
- R4: Code 6 (shift left) gives {a_i[6:0],0}. Carry takes a_i[7] and Overflow is cleared.
- R5: Code 7 (logical shift right) gives {0,a_i[7:1]}. Carry takes a_i[0] and Overflow is cleared.
- R6: Code 8 (pass) gives res_o = b_i. Carry and Overflow are cleared.
- R7: For every defined code, Zero is set when the result is 0 and Negative equals result bit 7. The flags_o bit positions are: bit 0 Zero, bit 1 Carry, bit 2 Negative, bit 3 Overflow.
- R8: flags_o changes only on a rising edge of clk_i where flag_en_i is high. Otherwise it holds its value.
- R9: Codes 9 to 15 give res_o = 0 and leave flags_o unchanged, even when flag_en_i is high.
- R10: While rst_ni is low, flags_o is 0, whatever the state of flag_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B, or an immediate value |
| op_i | input | 4 | Operation code |
| flag_en_i | input | 1 | Loads the status register on the next edge |
| res_o | output | 8 | Combinational result |
| flags_o | output | 4 | Registered flags: {Overflow, Negative, Carry, Zero} |

## Verification
The bench targets the boundaries of the adder.

| Case | What a faulty design would do |
|---|---|
| 0x7F+0x01 and 0x80-0x01 | Get the Overflow sign test wrong and miss signed overflow. |
| 0xFF+0x01 | Drop the ninth bit, losing Carry or setting Zero wrongly. |
| 3-5 | Report Carry as a borrow, the inverted sense. |
| 5-5 | Get Carry inverted on equal operands. |
| Shifts of 0x81 and 0x01 | Pick the wrong outgoing bit for Carry. |
| Enable low | Let a load corrupt the flags. |
| Undefined code with enable high | Let a stray code corrupt the flags. |

A random run against an independent model then covers the remaining cases.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOT  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_PASS = 4'd8
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = OP_PASS;

  typedef struct packed {
    logic v;
    logic n;
    logic c;
    logic z;
  } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  b_eff;
  logic [SW-1:0] full;

  // subtract = a + ~b + 1
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + SW'(sub_i);
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
  assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_flags_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o,
  output logic            cout_o
);
  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    case (alu_op_e'(op_i))
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      OP_SHL: begin
        res_o  = {a_i[W-2:0], 1'b0};
        cout_o = a_i[W-1];
      end
      OP_SHR: begin
        res_o  = {1'b0, a_i[W-1:1]};
        cout_o = a_i[0];
      end
      OP_PASS: res_o = b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o)); // R8
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            flag_en_i,
  output logic [W-1:0]    res_o,
  output logic [3:0]      flags_o
);
  logic         op_valid, is_arith, is_sub, is_logic;
  logic [W-1:0] sum, bit_res;
  logic         add_c, add_v, bit_c;
  flags_t       flags_d, flags_q;

  assign op_valid = (op_i <= OP_LAST);
  assign is_sub   = (op_i == OP_SUB);
  assign is_arith = (op_i == OP_ADD) || is_sub;
  assign is_logic = (op_i inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_PASS});

  alu_addsub #(.W(W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .sum_o (sum),
    .cout_o(add_c),
    .ovf_o (add_v)
  );

  alu_bitops #(.W(W)) u_bitops (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op_i),
    .res_o (bit_res),
    .cout_o(bit_c)
  );

  assign res_o = is_arith ? sum : bit_res;

  always_comb begin
    flags_d.z = (res_o == '0);
    flags_d.n = res_o[W-1];
    flags_d.c = is_arith ? add_c : bit_c;
    flags_d.v = is_arith & add_v;
  end

  alu_flag_reg u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(flag_en_i & op_valid),
    .d_i   (flags_d),
    .q_o   (flags_q)
  );

  assign flags_o = flags_q;

  AST_INVALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid |=> $stable(flags_o)); // R9
  AST_LOGIC_NO_CV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && is_logic) |=> (!flags_o[1] && !flags_o[3])); // R3
  AST_ZERO_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && op_valid) |=> (flags_o[0] == ($past(res_o) == '0))); // R7
  AST_SUB_NO_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && is_sub) |=> (flags_o[1] == ($past(a_i) >= $past(b_i)))); // R2
endmodule

// File: tb/sim_alu_flags_unit.sv
`timescale 1ns/100ps
module sim_alu_flags_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [3:0] op = '0;
  logic       en = 1'b0;
  logic [7:0] res;
  logic [3:0] flags;

  int checks = 0, fails = 0;
  logic [3:0] exp_flags = '0;
  logic [3:0] q_flags[$];
  string      q_tag[$];
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  alu_flags_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .op_i(op),
    .flag_en_i(en), .res_o(res), .flags_o(flags)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Independent model: result, carry, overflow, valid
  task automatic model(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                       output logic [7:0] r, output logic c, output logic v, output logic ok);
    logic [8:0] t;
    r = '0; c = 1'b0; v = 1'b0; ok = 1'b1;
    case (o)
      4'd0: begin t = x + y; r = t[7:0]; c = t[8];
              v = (x[7] == y[7]) && (r[7] != x[7]); end
      4'd1: begin r = x - y; c = (x >= y);
              v = (x[7] != y[7]) && (r[7] != x[7]); end
      4'd2: r = x & y;
      4'd3: r = x | y;
      4'd4: r = x ^ y;
      4'd5: r = ~x;
      4'd6: begin r = x << 1; c = x[7]; end
      4'd7: begin r = x >> 1; c = x[0]; end
      4'd8: r = y;
      default: ok = 1'b0;
    endcase
  endtask

  task automatic drive(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic e, input string tag);
    logic [7:0] r; logic c, v, ok;
    @(negedge clk);
    op = o; a = x; b = y; en = e;
    model(o, x, y, r, c, v, ok);
    #1;
    check({tag, " result"}, res, r);
    if (e && ok) exp_flags = {v, r[7], c, (r == 8'h00)};
    q_flags.push_back(exp_flags);
    q_tag.push_back(tag);
  endtask

  // Monitor: flags become visible after the edge following the drive
  always @(posedge clk) begin
    #1;
    if (q_flags.size() > 0) begin
      logic [3:0] f; string t;
      f = q_flags.pop_front();
      t = q_tag.pop_front();
      check({t, " flags"}, {4'b0, flags}, {4'b0, f});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: enable high during reset must not load
    op = 4'd1; a = 8'h03; b = 8'h05; en = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R10 flags in reset", {4'b0, flags}, 8'h00);
    @(negedge clk) rst_ni = 1'b1; en = 1'b0;
    #1 check("R10 flags after reset", {4'b0, flags}, 8'h00);

    drive(4'd0, 8'h7F, 8'h01, 1, "R1 add signed ovf");
    drive(4'd0, 8'hFF, 8'h01, 1, "R1 add carry zero");
    drive(4'd0, 8'h12, 8'h34, 1, "R1 add plain");
    drive(4'd1, 8'h05, 8'h03, 1, "R2 sub no borrow");
    drive(4'd1, 8'h03, 8'h05, 1, "R2 sub borrow");
    drive(4'd1, 8'h80, 8'h01, 1, "R2 sub signed ovf");
    drive(4'd1, 8'h05, 8'h05, 1, "R2 R7 sub equal");
    drive(4'd2, 8'hF0, 8'h3C, 1, "R3 and");
    drive(4'd3, 8'h0F, 8'h80, 1, "R3 or");
    drive(4'd4, 8'hAA, 8'hAA, 1, "R3 xor zero");
    drive(4'd5, 8'h0F, 8'h00, 1, "R3 not");
    drive(4'd6, 8'h81, 8'h00, 1, "R4 shl carry");
    drive(4'd7, 8'h01, 8'h00, 1, "R5 shr carry zero");
    drive(4'd7, 8'hFE, 8'h00, 1, "R5 shr no carry");
    drive(4'd8, 8'h00, 8'h9C, 1, "R6 pass");
    drive(4'd1, 8'h03, 8'h05, 1, "R8 setup");
    drive(4'd0, 8'h00, 8'h00, 0, "R8 hold with enable low");
    drive(4'd8, 8'h00, 8'h00, 0, "R8 hold pass");
    for (int k = 9; k < 16; k++) drive(4'(k), 8'h00, 8'h00, 1, "R9 undefined code");
    for (int i = 0; i < 300; i++)
      drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 1'($urandom),
            "R7 random");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule